// File: doc/BRIEF.md
# Transport Stream Input Packet Processor

This block sits behind a demodulator that hands over a transport stream one byte at a time. Each byte comes with a valid strobe and a flag saying whether the demodulator could decode it. The block hunts for packet boundaries by looking for the 0x47 sync byte. It works out whether packets are 188 or 204 bytes long and holds lock while the sync pattern stays in place. Only packets received while locked are passed downstream.

On the way through, every forwarded packet is stamped with its time of arrival. A 32-bit counter on the block clock is sampled when byte position 10 (the eleventh byte) of the packet is accepted. The four bytes of that sample are then appended after the last packet byte. The output stream carries start and end markers, and an outgoing packet is four bytes longer than the incoming one.

Two saturating counters track sync losses and undecodable bytes, and a synchronous clear input resets both. An error flag compares the byte error count against a limit supplied on a port.

Top module: `tsin_pkt_proc`

## Requirements
- R1: The block reaches lock when it finds 0x47 at three consecutive packet starts spaced by the same length, either 188 or 204 bytes. `locked` rises in the cycle after the third such sync byte is accepted, and the packet that begins with that third sync byte is the first one forwarded.
- R2: `long_pkt` is 1 when the detected spacing is 204 bytes and 0 when it is 188 bytes. It is 0 after reset and does not change while lock is held.
- R3: While `locked` is low, no input byte reaches the output. After reset, `locked`, `out_valid` and both counters are 0.
- R4: While locked, each expected packet start that does not hold 0x47 increments `sync_loss_cnt` by one. That packet is still forwarded, with its first byte marked as start of packet.
- R5: Three consecutive missed packet starts drop lock. The third missed packet is not forwarded, and the search for sync begins again with the following byte.
- R6: Each valid input byte with `in_err` high increments `data_err_cnt` by one, whether or not the block is locked.
- R7: `err_flag` is 1 exactly when `data_err_cnt` is strictly greater than `err_limit`.
- R8: The timestamp counter is 0 in reset and advances by one on every clock. Its value on the edge that accepts byte position 10 of a forwarded packet is appended after that packet's last byte, most significant byte first. This gives 192-byte or 208-byte output packets, with `out_sop` on the first byte and `out_eop` only on the last timestamp byte.
- R9: Both counters stop at their all-ones value.
- R10: `clr` high sets both counters to 0 on the next edge, and it takes priority over any increment in the same cycle.
- R11: When input bytes arrive no more often than every second clock, the output keeps every forwarded byte and every timestamp byte, in order and without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the timestamp time base |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of both counters |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input stream byte |
| in_err | input | 1 | Input byte could not be decoded |
| err_limit | input | CNT_W | Acceptable number of byte errors |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output stream byte |
| out_sop | output | 1 | First byte of an output packet |
| out_eop | output | 1 | Last timestamp byte of an output packet |
| locked | output | 1 | Packet lock held |
| long_pkt | output | 1 | Detected length is 204 (1) or 188 (0) |
| err_flag | output | 1 | Byte error count above limit |
| sync_loss_cnt | output | CNT_W | Saturating count of missed sync bytes |
| data_err_cnt | output | CNT_W | Saturating count of undecodable bytes |

## Verification
A missed sync byte that also carries the decode-error flag bumps both counters on the same edge. The bench sends such a packet while locked and then expects each counter to be exactly one higher. The clear can also land on the same edge as an errored byte: the bench drives both in one cycle and requires the error counter to read 0 afterwards rather than 1. In the timestamp path, the tail of one packet drains from the output buffer while the start of the next packet is being pushed in. The bench compares the full output byte stream, including the start and end markers and the timestamps computed from its own cycle count, against a model built from the stimulus.

// File: rtl/tsin_pkg.sv
package tsin_pkg;

    localparam logic [7:0] SYNC_BYTE   = 8'h47;
    localparam int         SHORT_LEN   = 188;
    localparam int         LONG_LEN    = 204;
    localparam int         STAMP_POS   = 10;
    localparam int         STAMP_W     = 32;
    localparam int         STAMP_BYTES = STAMP_W / 8;
    localparam int         POS_W       = 8;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } sync_state_e;

    typedef struct packed {
        logic [7:0]         data;
        logic               sop;
        logic               last;
        logic [STAMP_W-1:0] stamp;
    } fifo_entry_t;

    function automatic logic [POS_W-1:0] pkt_len(input logic long_sel);
        return long_sel ? POS_W'(LONG_LEN) : POS_W'(SHORT_LEN);
    endfunction

endpackage

// File: rtl/tsin_sync_fsm.sv
module tsin_sync_fsm
    import tsin_pkg::*;
#(
    parameter int LOCK_HITS  = 3,
    parameter int MISS_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       fwd,
    output logic       fwd_sop,
    output logic       fwd_last,
    output logic       fwd_stamp,
    output logic       locked,
    output logic       long_pkt,
    output logic       sync_miss
);

    localparam int HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);

    sync_state_e       state;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  cur_pos;
    logic [POS_W-1:0]  len_m1;
    logic              len_known;
    logic [HIT_W-1:0]  hits;
    logic [MISS_W-1:0] misses;
    logic              is_sync;
    logic              at_start;
    logic              lock_now;
    logic              drop_now;

    always_comb begin
        is_sync   = (in_data == SYNC_BYTE);
        len_m1    = pkt_len(long_pkt) - 1'b1;
        at_start  = len_known && (pos == len_m1);
        cur_pos   = at_start ? '0 : pos + 1'b1;
        lock_now  = in_valid && (state == ST_CONFIRM) && at_start && is_sync
                    && (32'(hits) + 1 >= LOCK_HITS);
        sync_miss = in_valid && (state == ST_LOCKED) && at_start && !is_sync;
        drop_now  = sync_miss && (32'(misses) + 1 >= MISS_LIMIT);
        fwd       = lock_now || (in_valid && (state == ST_LOCKED) && !drop_now);
        fwd_sop   = fwd && (cur_pos == '0);
        fwd_last  = fwd && (cur_pos == len_m1);
        fwd_stamp = fwd && (cur_pos == POS_W'(STAMP_POS));
    end

    assign locked = (state == ST_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            pos       <= '0;
            len_known <= 1'b0;
            long_pkt  <= 1'b0;
            hits      <= '0;
            misses    <= '0;
        end else if (in_valid) begin
            unique case (state)
                ST_HUNT: begin
                    if (is_sync) begin
                        state     <= ST_CONFIRM;
                        pos       <= '0;
                        hits      <= HIT_W'(1);
                        len_known <= 1'b0;
                    end
                end
                ST_CONFIRM: begin
                    if (!len_known) begin
                        if (is_sync && (32'(pos) + 1 == SHORT_LEN)) begin
                            len_known <= 1'b1;
                            long_pkt  <= 1'b0;
                            pos       <= '0;
                            hits      <= hits + 1'b1;
                        end else if (32'(pos) + 1 == LONG_LEN) begin
                            if (is_sync) begin
                                len_known <= 1'b1;
                                long_pkt  <= 1'b1;
                                pos       <= '0;
                                hits      <= hits + 1'b1;
                            end else begin
                                state <= ST_HUNT;
                            end
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end else if (at_start) begin
                        if (!is_sync) begin
                            state <= ST_HUNT;
                        end else begin
                            pos  <= '0;
                            hits <= hits + 1'b1;
                            if (lock_now) begin
                                state  <= ST_LOCKED;
                                misses <= '0;
                            end
                        end
                    end else begin
                        pos <= cur_pos;
                    end
                end
                ST_LOCKED: begin
                    pos <= cur_pos;
                    if (at_start) begin
                        if (is_sync) begin
                            misses <= '0;
                        end else if (drop_now) begin
                            state     <= ST_HUNT;
                            len_known <= 1'b0;
                        end else begin
                            misses <= misses + 1'b1;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/tsin_stats.sv
module tsin_stats #(
    parameter int CNT_W = 16,
    parameter int N_CNT = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic [N_CNT-1:0]            inc,
    output logic [N_CNT-1:0][CNT_W-1:0] cnt
);

    for (genvar g = 0; g < N_CNT; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt[g] <= '0;
            end else if (inc[g] && (cnt[g] != '1)) begin
                cnt[g] <= cnt[g] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsin_tail_fifo.sv
module tsin_tail_fifo
    import tsin_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  fifo_entry_t push_entry,
    output logic        full,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sop,
    output logic        out_eop
);

    localparam int AW = $clog2(DEPTH);
    localparam int TW = $clog2(STAMP_BYTES + 1);

    fifo_entry_t        mem [DEPTH];
    fifo_entry_t        head;
    logic [AW:0]        wr_ptr;
    logic [AW:0]        rd_ptr;
    logic               empty;
    logic [STAMP_W-1:0] tail_sr;
    logic [TW-1:0]      tail_left;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
    assign head  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wr_ptr[AW-1:0]] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            tail_sr   <= '0;
            tail_left <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            if (push && !full) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            if (tail_left != '0) begin
                out_valid <= 1'b1;
                out_data  <= tail_sr[STAMP_W-1 -: 8];
                tail_sr   <= tail_sr << 8;
                tail_left <= tail_left - 1'b1;
                out_eop   <= (tail_left == TW'(1));
            end else if (!empty) begin
                out_valid <= 1'b1;
                out_data  <= head.data;
                out_sop   <= head.sop;
                rd_ptr    <= rd_ptr + 1'b1;
                if (head.last) begin
                    tail_sr   <= head.stamp;
                    tail_left <= TW'(STAMP_BYTES);
                end
            end
        end
    end

endmodule

// File: rtl/tsin_pkt_proc.sv
module tsin_pkt_proc
    import tsin_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LOCK_HITS  = 3,
    parameter int MISS_LIMIT = 3,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_err,
    input  logic [CNT_W-1:0] err_limit,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             locked,
    output logic             long_pkt,
    output logic             err_flag,
    output logic [CNT_W-1:0] sync_loss_cnt,
    output logic [CNT_W-1:0] data_err_cnt
);

    logic               fwd;
    logic               fwd_sop;
    logic               fwd_last;
    logic               fwd_stamp;
    logic               sync_miss;
    logic               fifo_full;
    logic [STAMP_W-1:0] stamp_ctr;
    logic [STAMP_W-1:0] stamp_hold;
    fifo_entry_t        entry;
    logic [1:0][CNT_W-1:0] counts;

    tsin_sync_fsm #(
        .LOCK_HITS  (LOCK_HITS),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .fwd       (fwd),
        .fwd_sop   (fwd_sop),
        .fwd_last  (fwd_last),
        .fwd_stamp (fwd_stamp),
        .locked    (locked),
        .long_pkt  (long_pkt),
        .sync_miss (sync_miss)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_ctr  <= '0;
            stamp_hold <= '0;
        end else begin
            stamp_ctr <= stamp_ctr + 1'b1;
            if (fwd_stamp) begin
                stamp_hold <= stamp_ctr;
            end
        end
    end

    always_comb begin
        entry.data  = in_data;
        entry.sop   = fwd_sop;
        entry.last  = fwd_last;
        entry.stamp = stamp_hold;
    end

    tsin_tail_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_tail (
        .clk        (clk),
        .rst        (rst),
        .push       (fwd),
        .push_entry (entry),
        .full       (fifo_full),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sop    (out_sop),
        .out_eop    (out_eop)
    );

    tsin_stats #(
        .CNT_W (CNT_W),
        .N_CNT (2)
    ) u_stats (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .inc ({sync_miss, in_valid && in_err}),
        .cnt (counts)
    );

    assign data_err_cnt  = counts[0];
    assign sync_loss_cnt = counts[1];
    assign err_flag      = (data_err_cnt > err_limit);

endmodule

// File: rtl/tsin_pkt_proc_chk.sv
module tsin_pkt_proc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             in_err,
    input logic             locked,
    input logic             long_pkt,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic             fwd,
    input logic             fifo_full,
    input logic [CNT_W-1:0] sync_loss_cnt,
    input logic [CNT_W-1:0] data_err_cnt
);

    p_lock_on_sync_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(in_valid && (in_data == 8'h47)));

    p_size_hold_r2: assert property (@(posedge clk) disable iff (rst)
        locked |=> (!locked || $stable(long_pkt)));

    p_fwd_only_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (fwd && !locked) |=> locked);

    p_loss_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !locked) |=> (sync_loss_cnt == $past(sync_loss_cnt)));

    p_err_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && in_valid && in_err && (data_err_cnt != '1))
        |=> (data_err_cnt == $past(data_err_cnt) + 1'b1));

    p_eop_alone_r8: assert property (@(posedge clk) disable iff (rst)
        out_eop |-> (out_valid && !out_sop));

    p_err_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr && (data_err_cnt == '1)) |=> (data_err_cnt == '1));

    p_loss_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr && (sync_loss_cnt == '1)) |=> (sync_loss_cnt == '1));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((data_err_cnt == '0) && (sync_loss_cnt == '0)));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        fwd |-> !fifo_full);

endmodule

bind tsin_pkt_proc tsin_pkt_proc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .clr           (clr),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_err        (in_err),
    .locked        (locked),
    .long_pkt      (long_pkt),
    .out_valid     (out_valid),
    .out_sop       (out_sop),
    .out_eop       (out_eop),
    .fwd           (fwd),
    .fifo_full     (fifo_full),
    .sync_loss_cnt (sync_loss_cnt),
    .data_err_cnt  (data_err_cnt)
);

// File: tb/tsin_pkt_proc_bench.sv
`timescale 1ns/1ps
module tsin_pkt_proc_bench;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_err = 1'b0;
    logic [CW-1:0] err_limit = '0;
    logic          out_valid, out_sop, out_eop, locked, long_pkt, err_flag;
    logic [7:0]    out_data;
    logic [CW-1:0] sync_loss_cnt, data_err_cnt;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    logic [9:0] expq[$];
    logic [9:0] gotq[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc = 0;
        else     cyc = cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst && out_valid) gotq.push_back({out_sop, out_eop, out_data});
    end

    tsin_pkt_proc #(.CNT_W(CW)) u_tsin_pkt_proc (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_data(in_data),
        .in_err(in_err), .err_limit(err_limit), .out_valid(out_valid),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .locked(locked), .long_pkt(long_pkt), .err_flag(err_flag),
        .sync_loss_cnt(sync_loss_cnt), .data_err_cnt(data_err_cnt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] d, input bit e, output int at);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_err = e; at = cyc;
        @(negedge clk);
        in_valid = 1'b0; in_err = 1'b0;
    endtask

    task automatic send_pkt(input int len, input bit good, input int id,
                            input bit fwd_exp, input int err_at);
        int st = 0;
        int at;
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = (i == 0) ? (good ? 8'h47 : 8'h00) : 8'((id * 5 + i) & 63);
            put_byte(d, i == err_at, at);
            if (i == 10) st = at;
            if (fwd_exp) expq.push_back({i == 0, 1'b0, d});
        end
        if (fwd_exp) begin
            for (int b = 0; b < 4; b++) begin
                logic [31:0] sv = 32'(st);
                expq.push_back({1'b0, b == 3, sv[31 - 8 * b -: 8]});
            end
        end
    endtask

    task automatic compare_stream(input string req);
        int bad = -1;
        repeat (40) @(negedge clk);
        check(gotq.size() == expq.size(), req, "output byte count", gotq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < gotq.size(); i++)
            if (bad < 0 && gotq[i] != expq[i]) bad = i;
        if (bad >= 0) check(1'b0, req, "output stream entry {sop,eop,data}", gotq[bad], expq[bad]);
        else          check(1'b1, req, "output stream", 0, 0);
        gotq.delete();
        expq.delete();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        gotq.delete();
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int at;
        do_reset();
        check(locked == 1'b0, "R3", "locked after reset", locked, 0);
        check(out_valid == 1'b0, "R3", "out_valid after reset", out_valid, 0);
        check(data_err_cnt == 0 && sync_loss_cnt == 0, "R3", "counters after reset",
              data_err_cnt + sync_loss_cnt, 0);
        check(long_pkt == 1'b0, "R2", "size flag after reset", long_pkt, 0);

        // 188-byte stream: lock on the third packet
        put_byte(8'h00, 1'b0, at);
        put_byte(8'h00, 1'b0, at);
        send_pkt(188, 1, 0, 0, -1);
        send_pkt(188, 1, 1, 0, -1);
        check(locked == 1'b0, "R1", "locked after two syncs", locked, 0);
        repeat (10) @(negedge clk);
        check(gotq.size() == 0, "R3", "bytes out while hunting", gotq.size(), 0);
        send_pkt(188, 1, 2, 1, -1);
        check(locked == 1'b1, "R1", "locked after third sync", locked, 1);
        send_pkt(188, 1, 3, 1, -1);
        send_pkt(188, 1, 4, 1, -1);
        check(long_pkt == 1'b0, "R2", "size flag for 188", long_pkt, 0);
        check(sync_loss_cnt == 0, "R4", "no sync loss on clean stream", sync_loss_cnt, 0);
        compare_stream("R8");

        // 204-byte stream with errors, misses and lock loss
        do_reset();
        put_byte(8'h00, 1'b1, at);
        send_pkt(204, 1, 10, 0, 5);
        send_pkt(204, 1, 11, 0, 7);
        check(data_err_cnt == 3, "R6", "errors while hunting", data_err_cnt, 3);
        err_limit = 4'd3; #1;
        check(err_flag == 1'b0, "R7", "flag at count equal to limit", err_flag, 0);
        err_limit = 4'd2; #1;
        check(err_flag == 1'b1, "R7", "flag above limit", err_flag, 1);
        send_pkt(204, 1, 12, 1, -1);
        check(locked == 1'b1, "R1", "locked on 204 stream", locked, 1);
        check(long_pkt == 1'b1, "R2", "size flag for 204", long_pkt, 1);
        send_pkt(204, 0, 13, 1, -1);
        check(sync_loss_cnt == 1, "R4", "one missed sync", sync_loss_cnt, 1);
        check(locked == 1'b1, "R4", "lock kept after one miss", locked, 1);
        send_pkt(204, 1, 14, 1, -1);
        send_pkt(204, 0, 15, 1, 0);
        check(sync_loss_cnt == 2, "R4", "miss with errored sync byte", sync_loss_cnt, 2);
        check(data_err_cnt == 4, "R6", "error on missed sync byte", data_err_cnt, 4);
        send_pkt(204, 0, 16, 1, -1);
        send_pkt(204, 0, 17, 0, -1);
        check(locked == 1'b0, "R5", "lock dropped on third miss", locked, 0);
        check(sync_loss_cnt == 4, "R5", "misses counted", sync_loss_cnt, 4);
        send_pkt(204, 1, 18, 0, -1);
        send_pkt(204, 1, 19, 0, -1);
        send_pkt(204, 1, 20, 1, -1);
        check(locked == 1'b1, "R1", "relock after loss", locked, 1);
        compare_stream("R11");

        // repeated lock loss drives the sync loss counter to saturation
        do_reset();
        for (int r = 0; r < 6; r++) begin
            send_pkt(188, 1, 30 + 6 * r, 0, -1);
            send_pkt(188, 1, 31 + 6 * r, 0, -1);
            send_pkt(188, 1, 32 + 6 * r, 1, -1);
            send_pkt(188, 0, 33 + 6 * r, 1, -1);
            send_pkt(188, 0, 34 + 6 * r, 1, -1);
            send_pkt(188, 0, 35 + 6 * r, 0, -1);
        end
        check(sync_loss_cnt == 15, "R9", "sync loss saturates", sync_loss_cnt, 15);
        check(locked == 1'b0, "R5", "unlocked after final third miss", locked, 0);
        compare_stream("R5");

        // byte error saturation and clear priority
        for (int k = 0; k < 20; k++) put_byte(8'h00, 1'b1, at);
        check(data_err_cnt == 15, "R9", "error count saturates", data_err_cnt, 15);
        @(negedge clk);
        clr = 1'b1; in_valid = 1'b1; in_data = 8'h00; in_err = 1'b1;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0; in_err = 1'b0;
        check(data_err_cnt == 0, "R10", "clear beats increment", data_err_cnt, 0);
        check(sync_loss_cnt == 0, "R10", "clear of sync loss", sync_loss_cnt, 0);
        put_byte(8'h00, 1'b1, at);
        check(data_err_cnt == 1, "R10", "count resumes after clear", data_err_cnt, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule